// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit buses, A and B. It has one storage register for each direction. Each direction has its own capture clock, its own source select and its own drive enable. When the B side is enabled, it carries either the live A value or the stored A-to-B word. The A side works the same way with the live B value or the stored B-to-A word. Every driven value is the bitwise inverse of its selected source. Each tri-state bus is split into an input vector, an output vector and an output-enable vector.

The capture clocks are asynchronous strobes. The block samples them on the system clock `clk`. A word is stored on the first `clk` edge that sees its capture strobe high after it was low. Capture does not depend on the selects or the enables. A small link state machine has two states, `LINK_OPEN` and `LINK_LOOP`. It moves `LINK_OPEN -> LINK_LOOP` when both directions are live and both sides are driven. It moves `LINK_LOOP -> LINK_OPEN` as soon as that condition ends. While the loop condition holds in `LINK_LOOP`, each bus is fed back through the opposite path. Two bus keepers stand in for the wires, so the buses keep their last state once the outside drivers let go.

Top module: `regbus_xcvr`

## Requirements
- R1: After the asynchronous active-low reset, both storage registers hold zero and the link state is `LINK_OPEN`. A side that is enabled in stored mode therefore drives all ones.
- R2: The A-to-B register loads `a_in` on the first `clk` rising edge that samples `cap_ab` high after it was sampled low. From the cycle after that edge, `b_out` in stored mode (`src_ab`=1) is the inverse of the loaded word.
- R3: The B-to-A register loads `b_in` in the same way on a rising `cap_ba`. `a_out` in stored mode (`src_ba`=1) is then its inverse.
- R4: Capture happens whatever the values of `src_ab`, `src_ba`, `drv_b` and `drv_a_n`.
- R5: `src_ab`=0 makes `b_out` equal `~a_in` in the same cycle, and `src_ab`=1 makes it the inverse of the stored word. `src_ba` selects for `a_out` in the same way.
- R6: `b_oe` is all ones when `drv_b`=1 and all zeros otherwise. `a_oe` is all ones when `drv_a_n`=0 and all zeros otherwise. Both are combinational.
- R7: Every driven output bit is the inverse of the matching bit of its selected source.
- R8: When `src_ab`=0, `src_ba`=0, `drv_b`=1 and `drv_a_n`=0 hold across a `clk` edge, the state becomes `LINK_LOOP` and the buses are looped.
  - While one bus has an external driver (`a_ext` or `b_ext`=1), the other bus carries its inverse.
  - With no external driver, `a_out` holds the last A bus value and `b_out` holds its inverse, unchanged from cycle to cycle.
- R9: Holding a capture strobe high stores nothing new. Only its rising edge loads a word.
- R10: When the loop condition ends, the outputs follow the selects again in the same cycle, and the state is back to `LINK_OPEN` after the next `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the capture strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_ab | input | 1 | Capture strobe of the A-to-B register |
| cap_ba | input | 1 | Capture strobe of the B-to-A register |
| src_ab | input | 1 | B-side source: 0 live A, 1 stored word |
| src_ba | input | 1 | A-side source: 0 live B, 1 stored word |
| drv_b | input | 1 | Active-high enable of the B side drive |
| drv_a_n | input | 1 | Active-low enable of the A side drive |
| a_in | input | 8 | Value seen on bus A |
| a_ext | input | 1 | Another driver is active on bus A |
| b_in | input | 8 | Value seen on bus B |
| b_ext | input | 1 | Another driver is active on bus B |
| a_out | output | 8 | Value driven onto bus A |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| b_out | output | 8 | Value driven onto bus B |
| b_oe | output | 8 | Per-bit drive enable for bus B |

## Verification
Live transfer, source selection and the enables are combinational. They are due in the same cycle as the stimulus. A stored word appears one `clk` edge after its strobe is first sampled high, and the loop engages on the edge after its condition. The bench changes inputs on the falling edge. It lets exactly one rising edge pass, or several when it waits for a hold to settle, and samples on the next falling edge. Capture data is set one cycle before the strobe rises and held one cycle after it, so it meets the setup and hold ordering.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        LINK_OPEN = 1'b0,
        LINK_LOOP = 1'b1
    } link_state_t;

endpackage

// File: rtl/xcvr_capreg.sv
module xcvr_capreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            q     <= '0;
        end else begin
            cap_q <= cap_clk;
            if (cap_clk && !cap_q) begin
                q <= d;
            end
        end
    end

    // R2 R3
    load_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_clk && !cap_q) |=> (q == $past(d)));

    // R9
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_clk && cap_q) |=> $stable(q));

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drv,
    input  logic [W-1:0] val,
    output logic [W-1:0] keep
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep <= '0;
        end else if (drv) begin
            keep <= val;
        end
    end

    // R8
    keep_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv |=> $stable(keep));

endmodule

// File: rtl/xcvr_linkfsm.sv
module xcvr_linkfsm
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_cond,
    output logic hold
);

    link_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            LINK_OPEN: if (loop_cond)  state_nx = LINK_LOOP;
            LINK_LOOP: if (!loop_cond) state_nx = LINK_OPEN;
            default:                   state_nx = LINK_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LINK_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            LINK_LOOP: hold = loop_cond;
            default:   hold = 1'b0;
        endcase
    end

    // R8
    loop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_cond |=> (state == LINK_LOOP));

    // R10
    loop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_cond |=> (state == LINK_OPEN));

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         src_ab,
    input  logic         src_ba,
    input  logic         drv_b,
    input  logic         drv_a_n,
    input  logic [W-1:0] a_in,
    input  logic         a_ext,
    input  logic [W-1:0] b_in,
    input  logic         b_ext,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    logic [W-1:0] store_ab, store_ba;
    logic [W-1:0] keep_a, keep_b;
    logic [W-1:0] bus_a, bus_b;
    logic [W-1:0] src_a_val, src_b_val;
    logic [W-1:0] kval_a, kval_b;
    logic         kdrv_a, kdrv_b;
    logic         loop_cond, hold;

    xcvr_capreg #(.W(W)) u_cap_ab (
        .clk(clk), .rst_n(rst_n), .cap_clk(cap_ab), .d(a_in), .q(store_ab)
    );

    xcvr_capreg #(.W(W)) u_cap_ba (
        .clk(clk), .rst_n(rst_n), .cap_clk(cap_ba), .d(b_in), .q(store_ba)
    );

    assign loop_cond = !src_ab && !src_ba && drv_b && !drv_a_n;

    xcvr_linkfsm u_fsm (
        .clk(clk), .rst_n(rst_n), .loop_cond(loop_cond), .hold(hold)
    );

    // Resolved bus values while looped: an outside driver wins, else the keeper.
    always_comb begin
        bus_a = a_ext ? a_in : (b_ext ? ~b_in : keep_a);
        bus_b = b_ext ? b_in : (a_ext ? ~a_in : keep_b);
        src_a_val = hold ? bus_a : a_in;
        src_b_val = hold ? bus_b : b_in;
    end

    always_comb begin
        b_out = ~(src_ab ? store_ab : src_a_val);
        a_out = ~(src_ba ? store_ba : src_b_val);
        b_oe  = {W{drv_b}};
        a_oe  = {W{!drv_a_n}};
    end

    // Keeper update: outside driver, or own drive (looped: the opposite driver).
    always_comb begin
        kdrv_a = a_ext | (hold ? b_ext : !drv_a_n);
        kval_a = a_ext ? a_in : (hold ? ~b_in : a_out);
        kdrv_b = b_ext | (hold ? a_ext : drv_b);
        kval_b = b_ext ? b_in : (hold ? ~a_in : b_out);
    end

    xcvr_keeper #(.W(W)) u_keep_a (
        .clk(clk), .rst_n(rst_n), .drv(kdrv_a), .val(kval_a), .keep(keep_a)
    );

    xcvr_keeper #(.W(W)) u_keep_b (
        .clk(clk), .rst_n(rst_n), .drv(kdrv_b), .val(kval_b), .keep(keep_b)
    );

    // R6
    loop_drives_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ((&a_oe) && (&b_oe)));

    // R8
    loop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !a_ext && !b_ext && $past(hold && !a_ext && !b_ext))
            |-> ($stable(a_out) && $stable(b_out)));

endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;

    localparam int W = 8;

    typedef struct packed {
        logic         s_ab;
        logic         s_ba;
        logic         d_b;
        logic         d_a_n;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] eb;
        logic [W-1:0] ea;
        logic         eboe;
        logic         eaoe;
    } vec_t;

    // Stored words before the table: A-to-B 8'h3C, B-to-A 8'h81
    localparam vec_t VEC [8] = '{
        {1'b0,1'b1,1'b1,1'b1, 8'h5A,8'h00, 8'hA5,8'h00, 1'b1,1'b0},
        {1'b1,1'b0,1'b1,1'b1, 8'hFF,8'h00, 8'hC3,8'h00, 1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b0, 8'h00,8'h96, 8'h00,8'h69, 1'b0,1'b1},
        {1'b1,1'b1,1'b0,1'b0, 8'h00,8'h00, 8'h00,8'h7E, 1'b0,1'b1},
        {1'b1,1'b1,1'b1,1'b0, 8'h12,8'h34, 8'hC3,8'h7E, 1'b1,1'b1},
        {1'b0,1'b1,1'b1,1'b0, 8'hF0,8'h0F, 8'h0F,8'h7E, 1'b1,1'b1},
        {1'b1,1'b0,1'b1,1'b0, 8'hAA,8'h55, 8'hC3,8'hAA, 1'b1,1'b1},
        {1'b0,1'b0,1'b0,1'b1, 8'h33,8'hCC, 8'h00,8'h00, 1'b0,1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_ab = 1'b0, cap_ba = 1'b0;
    logic         src_ab = 1'b1, src_ba = 1'b1;
    logic         drv_b = 1'b1, drv_a_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_ext = 1'b1, b_ext = 1'b1;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    regbus_xcvr #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .src_ab(src_ab), .src_ba(src_ba), .drv_b(drv_b), .drv_a_n(drv_a_n),
        .a_in(a_in), .a_ext(a_ext), .b_in(b_in), .b_ext(b_ext),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Data one cycle before the strobe rises, held one cycle after it falls
    task automatic load_ab(input logic [W-1:0] v);
        @(negedge clk) a_in = v;
        @(negedge clk) cap_ab = 1'b1;
        @(negedge clk) cap_ab = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_ba(input logic [W-1:0] v);
        @(negedge clk) b_in = v;
        @(negedge clk) cap_ba = 1'b1;
        @(negedge clk) cap_ba = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: zero registers, stored mode on both sides
        chk("R1 b_out", b_out, 8'hFF);
        chk("R1 a_out", a_out, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 b_oe", b_oe, 8'hFF);
        chk("R1 a_oe", a_oe, 8'hFF);

        // R4: capture with live selects and both drives off
        src_ab = 1'b0; src_ba = 1'b0; drv_b = 1'b0; drv_a_n = 1'b1;
        load_ab(8'h3C);
        load_ba(8'h81);
        chk("R4 b_oe off", b_oe, 8'h00);
        src_ab = 1'b1; src_ba = 1'b1; drv_b = 1'b1; drv_a_n = 1'b0;
        @(negedge clk);
        chk("R2 R4 stored A-to-B", b_out, 8'hC3);
        chk("R3 R4 stored B-to-A", a_out, 8'h7E);

        // R9: strobe held high, new data must not load
        @(negedge clk) cap_ab = 1'b1; a_in = 8'h3C;
        @(negedge clk) a_in = 8'h11;
        repeat (3) @(negedge clk);
        chk("R9 held strobe", b_out, 8'hC3);
        cap_ab = 1'b0;
        @(negedge clk);

        // R5 R6 R7: table walk
        for (int i = 0; i < 8; i++) begin
            src_ab = VEC[i].s_ab; src_ba = VEC[i].s_ba;
            drv_b = VEC[i].d_b; drv_a_n = VEC[i].d_a_n;
            a_in = VEC[i].a; b_in = VEC[i].b;
            @(negedge clk);
            chk("R6 b_oe", b_oe, {W{VEC[i].eboe}});
            chk("R6 a_oe", a_oe, {W{VEC[i].eaoe}});
            if (VEC[i].eboe) chk("R5 R7 b_out", b_out, VEC[i].eb);
            if (VEC[i].eaoe) chk("R5 R7 a_out", a_out, VEC[i].ea);
        end

        // R8: loop with A driven from outside, then released
        src_ab = 1'b0; src_ba = 1'b0; drv_b = 1'b1; drv_a_n = 1'b0;
        a_ext = 1'b1; a_in = 8'h6B; b_ext = 1'b0; b_in = 8'hFF;
        repeat (2) @(negedge clk);
        chk("R8 B follows A", b_out, 8'h94);
        a_ext = 1'b0; a_in = 8'h00; b_in = 8'h00;
        repeat (3) @(negedge clk);
        chk("R8 hold a_out", a_out, 8'h6B);
        chk("R8 hold b_out", b_out, 8'h94);
        chk("R8 hold a_oe", a_oe, 8'hFF);

        // R8: loop with B driven from outside, then released
        b_ext = 1'b1; b_in = 8'h2D;
        repeat (2) @(negedge clk);
        chk("R8 A follows B", a_out, 8'hD2);
        b_ext = 1'b0; b_in = 8'hFF; a_in = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R8 hold b_out", b_out, 8'h2D);
        chk("R8 hold a_out", a_out, 8'hD2);

        // R10: leave the loop, outputs follow selects and live inputs
        a_ext = 1'b1; b_ext = 1'b1;
        src_ab = 1'b1; b_in = 8'h0F;
        #1;
        chk("R10 same-cycle stored", b_out, 8'hC3);
        chk("R10 same-cycle live", a_out, 8'hF0);
        @(negedge clk);
        src_ab = 1'b0; drv_a_n = 1'b1; a_in = 8'h0F;
        @(negedge clk);
        chk("R10 open live", b_out, 8'hF0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule